// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches the four active-low modem handshake inputs of a serial port: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them as one status word on a plain read port. The upper nibble of the byte shows the present state of each line as an active-high level. The lower nibble holds sticky flags that record that a line has changed since the last read. Every pin passes through a multi-flop synchroniser. Edges are found by comparing each new line state with the state held from the previous cycle.

Reading the word clears the change flags. A change that lands in the same cycle as the read is kept, so no event is lost. The ring flag records only the end of a ring, when the pin returns high. In loopback mode the four line states come from bits of the modem control output register instead of the pins. Changes written into those bits raise flags exactly as pin changes would. A level interrupt request is raised while any flag is set and the interrupt enable is high.

Top module: `modem_status_watch`

## Requirements
- R1: The change flags at bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set when their line state changes in either direction. Each flag stays set until a read clears it.
- R2: Bit 2 sets only when the ring pin goes from low to high, which is the state bit falling from 1 to 0. A high-to-low pin change sets no flag.
- R3: Bits 4, 5, 6 and 7 show the complement of the clear-to-send, data-set-ready, ring and carrier-detect pins, in that order. A pin change driven before clock edge k appears after edge k+SYNC_STAGES.
- R4: A cycle with `rdStrobe` high clears bits 0 to 3 at the end of that cycle. The data shown during the read is the value from before the clear.
- R5: If a line change is detected in the same cycle as a read, the flag for that line is set after the read rather than cleared.
- R6: With `loopEn` high, bit 4 follows `ctlBits[1]`, bit 5 follows `ctlBits[0]`, bit 6 follows `ctlBits[2]` and bit 7 follows `ctlBits[3]`, one clock after the change. The pins have no effect on the status.
- R7: In loopback mode, changes of the looped control bits set the change flags under the same rules as R1 and R2.
- R8: After reset every status bit is 0. Bits 8 and above of `statusData` are always 0.
- R9: `modemIrq` is high exactly when `irqEn` is high and at least one of bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctsPinN | input | 1 | Clear-to-send pin, active low |
| dsrPinN | input | 1 | Data-set-ready pin, active low |
| riPinN | input | 1 | Ring indicator pin, active low |
| dcdPinN | input | 1 | Carrier detect pin, active low |
| loopEn | input | 1 | Take line states from control bits |
| ctlBits | input | 4 | Modem control output register bits 3..0 |
| rdStrobe | input | 1 | Status register read in this cycle |
| irqEn | input | 1 | Modem-status interrupt enable |
| statusData | output | DATA_W | Status word: flags in 3..0, states in 7..4, zeros above |
| modemIrq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: a two-stage synchroniser and a 32-bit read word. The two stages give a fixed three-edge path from pin to status, so directed reads can be placed on the exact cycle where a change is detected and the R5 collision is hit on purpose. The wide word lets the bench watch that 24 bits stay at zero. The reference model holds the pins in a queue as deep as the synchroniser. It is compared against the outputs every cycle, through directed phases and then a long pseudo-random run that mixes pin toggles, reads, loopback switching and enable changes.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int NUM_LINES = 4;
  // line order inside every 4-bit vector: 0 cts, 1 dsr, 2 ri, 3 dcd
  localparam int RING_IDX = 2;

  typedef struct packed {
    logic clrFlags;  // read in progress: drop flags at cycle end
    logic loopSel;   // take line states from control bits
  } msr_strobe_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic        rdStrobe,
  input  logic        loopEn,
  output msr_strobe_t strb
);
  always_comb begin
    strb          = '0;
    strb.clrFlags = rdStrobe;
    strb.loopSel  = loopEn;
  end
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] pinsN,
  input  logic [3:0]           ctlBits,
  input  msr_strobe_t          strb,
  output logic [NUM_LINES-1:0] lineState,
  output logic [NUM_LINES-1:0] chgFlags
);
  logic [NUM_LINES-1:0] syncChain [SYNC_STAGES];
  logic [NUM_LINES-1:0] lineNow;
  logic [NUM_LINES-1:0] loopMap;
  logic [NUM_LINES-1:0] evt;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= '1;
          else       syncChain[s] <= pinsN;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[s] <= '1;
          else       syncChain[s] <= syncChain[s-1];
      end
    end
  endgenerate

  // loopback wiring: cts<-ctl1, dsr<-ctl0, ri<-ctl2, dcd<-ctl3
  assign loopMap = {ctlBits[3], ctlBits[2], ctlBits[0], ctlBits[1]};
  assign lineNow = strb.loopSel ? loopMap : ~syncChain[SYNC_STAGES-1];

  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_edge
      if (i == RING_IDX) begin : g_trail
        assign evt[i] = lineState[i] & ~lineNow[i];
      end else begin : g_any
        assign evt[i] = lineState[i] ^ lineNow[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineState <= '0;
      chgFlags  <= '0;
    end else begin
      lineState <= lineNow;
      chgFlags  <= (chgFlags & ~{NUM_LINES{strb.clrFlags}}) | evt;
    end
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && evt == '0) |=> chgFlags == '0); // R4
  AST_KEEP_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlags && evt[0]) |=> chgFlags[0]); // R5
  AST_RING_TRAIL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (lineState[RING_IDX] && !lineNow[RING_IDX] == 1'b0 && !chgFlags[RING_IDX])
      |=> !chgFlags[RING_IDX]); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlags[3] && !strb.clrFlags) |=> chgFlags[3]); // R1
  AST_LOOP_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.loopSel |=> lineState[0] == $past(ctlBits[1])); // R6
endmodule

// File: rtl/modem_status_watch.sv
module modem_status_watch
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctsPinN,
  input  logic              dsrPinN,
  input  logic              riPinN,
  input  logic              dcdPinN,
  input  logic              loopEn,
  input  logic [3:0]        ctlBits,
  input  logic              rdStrobe,
  input  logic              irqEn,
  output logic [DATA_W-1:0] statusData,
  output logic              modemIrq
);
  localparam int BYTE_W = 2 * NUM_LINES;

  msr_strobe_t          strb;
  logic [NUM_LINES-1:0] lineState;
  logic [NUM_LINES-1:0] chgFlags;

  msr_ctrl u_ctrl (
    .rdStrobe (rdStrobe),
    .loopEn   (loopEn),
    .strb     (strb)
  );

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .pinsN     ({dcdPinN, riPinN, dsrPinN, ctsPinN}),
    .ctlBits   (ctlBits),
    .strb      (strb),
    .lineState (lineState),
    .chgFlags  (chgFlags)
  );

  always_comb begin
    statusData             = '0;
    statusData[BYTE_W-1:0] = {lineState, chgFlags};
  end

  assign modemIrq = irqEn & (|chgFlags);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusData[DATA_W-1:BYTE_W] == '0); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !modemIrq); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[3:0] == '0) |-> !modemIrq); // R9
endmodule

// File: tb/test_modem_status_watch.sv
module test_modem_status_watch;
  localparam int SYNC = 2;
  localparam int DW   = 32;

  logic clk = 0, rstN = 0;
  logic ctsN = 1, dsrN = 1, riN = 1, dcdN = 1;
  logic loopEn = 0, rdStrobe = 0, irqEn = 0;
  logic [3:0] ctlBits = 0;
  logic [DW-1:0] statusData;
  logic modemIrq;

  int compared = 0, mismatched = 0, cycles = 0;
  string tag = "R8";

  // reference model state
  logic [3:0] pinQ[$];
  logic [3:0] mState = 0, mFlags = 0;

  modem_status_watch #(.SYNC_STAGES(SYNC), .DATA_W(DW)) i_modem_status_watch (
    .clk(clk), .rstN(rstN), .ctsPinN(ctsN), .dsrPinN(dsrN), .riPinN(riN),
    .dcdPinN(dcdN), .loopEn(loopEn), .ctlBits(ctlBits), .rdStrobe(rdStrobe),
    .irqEn(irqEn), .statusData(statusData), .modemIrq(modemIrq));

  always #2 clk = ~clk;  // 250 MHz

  task automatic model_reset();
    pinQ.delete();
    for (int k = 0; k < SYNC; k++) pinQ.push_back(4'hF);
    mState = 0; mFlags = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    logic [3:0] src, nowV, ev;
    cycles++;
    if (!rstN) model_reset();
    else begin
      src  = pinQ.pop_front();
      pinQ.push_back({dcdN, riN, dsrN, ctsN});
      // loop: state0<-ctl1, state1<-ctl0, state2<-ctl2, state3<-ctl3
      nowV = loopEn ? {ctlBits[3], ctlBits[2], ctlBits[0], ctlBits[1]} : ~src;
      for (int k = 0; k < 4; k++)
        ev[k] = (k == 2) ? (mState[k] && !nowV[k]) : (mState[k] != nowV[k]);
      mFlags = (rdStrobe ? 4'h0 : mFlags) | ev;
      mState = nowV;
    end
    #1;
    begin
      logic [DW-1:0] expData;
      logic expIrq;
      expData = '0;
      expData[7:0] = {mState, mFlags};
      expIrq = irqEn && (mFlags != 0);
      compared++;
      if (statusData !== expData) begin
        mismatched++;
        $display("FAIL %s data: actual %h expected %h", tag, statusData, expData);
      end
      compared++;
      if (modemIrq !== expIrq) begin
        mismatched++;
        $display("FAIL R9 irq (%s): actual %b expected %b", tag, modemIrq, expIrq);
      end
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog (%s): actual hung expected finish", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readOnce();
    rdStrobe = 1; step(1); rdStrobe = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    step(3);
    rstN = 1;                 // released at negedge
    tag = "R8"; step(2);

    tag = "R1"; ctsN = 0; step(5); ctsN = 1; step(5);
    tag = "R3"; dsrN = 0; dcdN = 0; step(5);
    tag = "R4"; readOnce(); step(3);
    dsrN = 1; dcdN = 1; step(5); readOnce(); step(2);

    tag = "R2"; riN = 0; step(5); readOnce(); step(2);
    riN = 1; step(5); readOnce(); step(2);

    tag = "R5"; ctsN = 0; step(SYNC); rdStrobe = 1; step(1); rdStrobe = 0;
    step(3); readOnce(); step(2);

    tag = "R6"; loopEn = 1; step(2); readOnce();
    ctlBits = 4'b0010; step(2); ctlBits = 4'b1101; step(2);
    ctsN = 1; dsrN = 0; riN = 0; dcdN = 0; step(6);
    tag = "R7"; readOnce(); ctlBits = 4'b1011; step(2); ctlBits = 4'b0000;
    step(2); readOnce(); loopEn = 0; step(6); readOnce();
    ctsN = 1; dsrN = 1; riN = 1; dcdN = 1; step(6);

    tag = "R9"; irqEn = 1; readOnce(); step(2); ctsN = 0; step(5);
    irqEn = 0; step(2); irqEn = 1; readOnce(); step(3);

    tag = "R5"; lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) ctsN = ~ctsN;
      if (lfsr[3] && lfsr[1]) dsrN = ~dsrN;
      if (lfsr[5] && lfsr[2]) riN = ~riN;
      if (lfsr[7] && lfsr[4]) dcdN = ~dcdN;
      rdStrobe = lfsr[8] & lfsr[6];
      if (lfsr[15:11] == 0) loopEn = ~loopEn;
      if (lfsr[9]) ctlBits = lfsr[13:10];
      irqEn = lfsr[14] | lfsr[1];
      step(1);
    end
    rdStrobe = 0; step(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule